// File: doc/BRIEF.md
# Advanced-Load Address Check Table

This block tracks loads that a compiler has hoisted above stores whose addresses it could not disambiguate. When such a load executes, the pipeline inserts the load's address into the table, tagged with the load's destination register. Every store that executes afterwards probes all valid entries at once and kills each entry whose address falls in the same aligned 8-byte word. When the program reaches the point where the loaded value is first needed, it issues a check for that register. The check passes only if the register's entry is still present and valid. If the check fails, the surrounding pipeline must branch to recovery code that repeats the load.

The table holds a fixed number of entries. Each entry belongs to one register. A second insert for a register overwrites that register's entry in place. An insert for a new register takes the lowest free entry. When no entry is free, the insert takes the entry under a rotating pointer. Both a passing check and a failing check remove the register's entry. A flush input empties the whole table in one cycle. The response to a check comes out one cycle after the check is presented.

Top module: `ald_check_table`

## Requirements
- R1: Coming out of reset, the table is empty and `chk_resp_valid` is low. A check issued immediately after reset reports `chk_resp_fail` = 1.
- R2: A check for a register that was inserted and not disturbed afterwards reports `chk_resp_fail` = 0.
- R3: A store kills an entry when the store's address bits [ADDR_W-1:3] equal those of the entry, so any byte offset inside the same aligned 8-byte word matches. A store to a different word leaves the entry in place.
- R4: A single store kills every valid entry whose word matches, not only the first one found.
- R5: An insert for a register that already owns an entry overwrites that entry's address. After that, a store to the old word does not disturb the register, and a store to the new word does.
- R6: When all 16 entries are valid, an insert for a new register replaces the entry under a rotating pointer. The pointer starts at entry 0 and advances by one, wrapping, after each such replacement. Free entries are filled lowest index first. A check for the register that was evicted fails.
- R7: A check removes the register's entry, so a second check for the same register fails unless the register has been inserted again in between.
- R8: When `flush` is high, all entries are emptied by the next cycle. Inserts presented in the flush cycle are dropped, and checks presented in that cycle fail.
- R9: When a store and a check arrive in the same cycle and the store's word matches the checked entry, the store takes effect first and the check fails. A store to a different word in the same cycle does not affect the check.
- R10: A check for a register that was never inserted fails.
- R11: An insert and a store to the same word in the same cycle leave the new entry valid. The store acts only on entries that existed before that cycle.
- R12: `chk_resp_valid` is high in exactly the cycle after each cycle in which `chk_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Empty the whole table |
| ins_valid | input | 1 | Insert request from a speculative load |
| ins_reg | input | REG_W (7) | Destination register of the speculative load |
| ins_addr | input | ADDR_W-3 (61) | Load address, bits [ADDR_W-1:3] |
| st_valid | input | 1 | Store probe request |
| st_addr | input | ADDR_W-3 (61) | Store address, bits [ADDR_W-1:3] |
| chk_valid | input | 1 | Check request |
| chk_reg | input | REG_W (7) | Register being checked |
| chk_resp_valid | output | 1 | Check response strobe, one cycle after the check |
| chk_resp_fail | output | 1 | 1 means the entry was invalidated or missing and recovery code must run |

## Verification
The assertions assume that the inputs are never X while reset is released. They also assume that the insert, store and check strobes each describe at most one operation per cycle. The store-clearing property is checked only in cycles without a simultaneous insert, because R11 allows a new entry at a just-stored word. The bench drives every strobe for exactly one cycle, applies it shortly after the clock edge, and uses register numbers within the 7-bit range. The fill-and-evict sequence starts from a freshly flushed table that has never been full, so the rotating pointer begins at entry 0.

// File: rtl/ald_pkg.sv
// Shared types for the advanced-load address check table.
// Assumes nothing beyond standard SystemVerilog enum support.
package ald_pkg;

    // Reason an insert picked the slot it writes.
    typedef enum logic [1:0] {
        SLOT_NONE     = 2'd0,
        SLOT_SAME_REG = 2'd1,
        SLOT_FREE     = 2'd2,
        SLOT_ROTATE   = 2'd3
    } slot_src_e;

endpackage

// File: rtl/ald_lookup.sv
// Associative compare across all table entries.
// Produces three hit vectors: store word match, insert register match
// and check register match. Only valid entries can hit.
// Assumes the table holds at most one valid entry per register.
module ald_lookup #(
    parameter int ENTRIES = 16,
    parameter int REG_W   = 7,
    parameter int WORD_W  = 61
) (
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic [REG_W-1:0]   ent_reg  [ENTRIES],
    input  logic [WORD_W-1:0]  ent_word [ENTRIES],
    input  logic               st_valid,
    input  logic [WORD_W-1:0]  st_word,
    input  logic [REG_W-1:0]   ins_reg,
    input  logic [REG_W-1:0]   chk_reg,
    output logic [ENTRIES-1:0] st_hit,
    output logic [ENTRIES-1:0] ins_hit,
    output logic [ENTRIES-1:0] chk_hit
);

    // One comparator set per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign st_hit[g]  = st_valid && ent_valid[g] && (ent_word[g] == st_word);
        assign ins_hit[g] = ent_valid[g] && (ent_reg[g] == ins_reg);
        assign chk_hit[g] = ent_valid[g] && (ent_reg[g] == chk_reg);
    end

endmodule

// File: rtl/ald_victim.sv
// Slot selection for inserts.
// Order of choice: the register's own entry, then the lowest free entry,
// then the entry under a rotating pointer. The pointer advances only when
// it is used to evict.
// Assumes ins_hit is one-hot or zero.
module ald_victim
    import ald_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               ins_valid,
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic [ENTRIES-1:0] ins_hit,
    output logic [ENTRIES-1:0] slot_oh,
    output slot_src_e          slot_src
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rot_ptr;

    // Pick the target slot for the current insert.
    always_comb begin
        slot_oh  = '0;
        slot_src = SLOT_NONE;
        if (|ins_hit) begin
            slot_oh  = ins_hit;
            slot_src = SLOT_SAME_REG;
        end else if (!(&ent_valid)) begin
            for (int i = ENTRIES - 1; i >= 0; i--) begin
                if (!ent_valid[i]) begin
                    slot_oh = ENTRIES'(1) << i;
                end
            end
            slot_src = SLOT_FREE;
        end else begin
            slot_oh  = ENTRIES'(1) << rot_ptr;
            slot_src = SLOT_ROTATE;
        end
    end

    // Advance the rotating pointer after each eviction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rot_ptr <= '0;
        end else if (ins_valid && !flush && slot_src == SLOT_ROTATE) begin
            rot_ptr <= (rot_ptr == LAST) ? '0 : rot_ptr + 1'b1;
        end
    end

    // R5: a register owns at most one entry
    a_r5_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ins_hit));

    // R6: every insert lands in exactly one slot
    a_r6_slot_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> $onehot(slot_oh));

endmodule

// File: rtl/ald_check_table.sv
// Advanced-load address check table, top level.
// Holds one entry per speculatively loaded register: the register number
// and the 8-byte word address. Stores kill matching entries, and checks
// report whether the entry survived and then remove it.
// Assumes addresses arrive with the byte offset bits already dropped.
module ald_check_table
    import ald_pkg::*;
#(
    parameter int ENTRIES  = 16,
    parameter int REG_W    = 7,
    parameter int ADDR_W   = 64,
    parameter int WORD_LSB = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       ins_valid,
    input  logic [REG_W-1:0]           ins_reg,
    input  logic [ADDR_W-1:WORD_LSB]   ins_addr,
    input  logic                       st_valid,
    input  logic [ADDR_W-1:WORD_LSB]   st_addr,
    input  logic                       chk_valid,
    input  logic [REG_W-1:0]           chk_reg,
    output logic                       chk_resp_valid,
    output logic                       chk_resp_fail
);

    localparam int WORD_W = ADDR_W - WORD_LSB;

    logic [ENTRIES-1:0] ent_valid;
    logic [ENTRIES-1:0] valid_nx;
    logic [REG_W-1:0]   ent_reg  [ENTRIES];
    logic [WORD_W-1:0]  ent_word [ENTRIES];
    logic [ENTRIES-1:0] st_hit;
    logic [ENTRIES-1:0] ins_hit;
    logic [ENTRIES-1:0] chk_hit;
    logic [ENTRIES-1:0] slot_oh;
    slot_src_e          slot_src;
    logic               chk_survives;

    ald_lookup #(
        .ENTRIES (ENTRIES),
        .REG_W   (REG_W),
        .WORD_W  (WORD_W)
    ) i_lookup (
        .ent_valid (ent_valid),
        .ent_reg   (ent_reg),
        .ent_word  (ent_word),
        .st_valid  (st_valid),
        .st_word   (st_addr),
        .ins_reg   (ins_reg),
        .chk_reg   (chk_reg),
        .st_hit    (st_hit),
        .ins_hit   (ins_hit),
        .chk_hit   (chk_hit)
    );

    ald_victim #(
        .ENTRIES (ENTRIES)
    ) i_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .ins_valid (ins_valid),
        .ent_valid (ent_valid),
        .ins_hit   (ins_hit),
        .slot_oh   (slot_oh),
        .slot_src  (slot_src)
    );

    // Next valid bits: the store kills first, then the check removes, then the insert sets.
    always_comb begin
        valid_nx = ent_valid & ~st_hit;
        if (chk_valid) begin
            valid_nx = valid_nx & ~chk_hit;
        end
        if (ins_valid) begin
            valid_nx = valid_nx | slot_oh;
        end
        if (flush) begin
            valid_nx = '0;
        end
    end

    // Valid bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
        end else begin
            ent_valid <= valid_nx;
        end
    end

    // Entry payload write on insert.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_reg[g]  <= '0;
                ent_word[g] <= '0;
            end else if (ins_valid && !flush && slot_oh[g]) begin
                ent_reg[g]  <= ins_reg;
                ent_word[g] <= ins_addr;
            end
        end
    end

    // The check passes only if its entry exists and no store kills it this cycle.
    assign chk_survives = |(chk_hit & ~st_hit);

    // Registered check response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_resp_valid <= 1'b0;
            chk_resp_fail  <= 1'b0;
        end else begin
            chk_resp_valid <= chk_valid;
            chk_resp_fail  <= flush || !chk_survives;
        end
    end

    // Checker state: last store word, and whether a valid entry still holds it.
    logic [WORD_W-1:0] sv_st_word;
    logic              sv_stale;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_st_word <= '0;
        end else begin
            sv_st_word <= st_addr;
        end
    end

    always_comb begin
        sv_stale = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (ent_valid[i] && ent_word[i] == sv_st_word) begin
                sv_stale = 1'b1;
            end
        end
    end

    // R12: a response follows each check
    a_r12_resp_on: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> chk_resp_valid);

    // R12: no response without a check
    a_r12_resp_off: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !chk_resp_valid);

    // R8: flush empties the table
    a_r8_flush_clear: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ent_valid == '0));

    // R3: no valid entry keeps a word just stored to
    a_r3_store_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !ins_valid && !flush) |=> !sv_stale);

    // R6: occupancy grows by at most one per cycle
    a_r6_growth: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(ent_valid) <= $past($countones(ent_valid)) + 1));

endmodule

// File: tb/test_ald_check_table.sv
// Scoreboard bench: driver tasks queue the expected check results and a
// monitor pops them as responses appear.
module test_ald_check_table;

    localparam int REG_W  = 7;
    localparam int ADDR_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic              ins_valid = 1'b0;
    logic [REG_W-1:0]  ins_reg = '0;
    logic [ADDR_W-1:3] ins_addr = '0;
    logic              st_valid = 1'b0;
    logic [ADDR_W-1:3] st_addr = '0;
    logic              chk_valid = 1'b0;
    logic [REG_W-1:0]  chk_reg = '0;
    logic              chk_resp_valid;
    logic              chk_resp_fail;

    int    n_checks = 0;
    int    n_fail = 0;
    int    n_issued = 0;
    int    n_resp = 0;
    bit    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    ald_check_table i_ald_check_table (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush          (flush),
        .ins_valid      (ins_valid),
        .ins_reg        (ins_reg),
        .ins_addr       (ins_addr),
        .st_valid       (st_valid),
        .st_addr        (st_addr),
        .chk_valid      (chk_valid),
        .chk_reg        (chk_reg),
        .chk_resp_valid (chk_resp_valid),
        .chk_resp_fail  (chk_resp_fail)
    );

    task automatic step();
        @(posedge clk);
        #1;
        flush = 1'b0; ins_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0;
    endtask

    task automatic set_ins(input int r, input logic [63:0] a);
        ins_valid = 1'b1; ins_reg = REG_W'(r); ins_addr = a[63:3];
    endtask

    task automatic set_st(input logic [63:0] a);
        st_valid = 1'b1; st_addr = a[63:3];
    endtask

    task automatic set_chk(input int r, input bit exp_fail, input string tag);
        chk_valid = 1'b1; chk_reg = REG_W'(r);
        exp_q.push_back(exp_fail); tag_q.push_back(tag);
        n_issued++;
    endtask

    task automatic ins(input int r, input logic [63:0] a);
        set_ins(r, a); step();
    endtask

    task automatic st(input logic [63:0] a);
        set_st(a); step();
    endtask

    task automatic chk(input int r, input bit exp_fail, input string tag);
        set_chk(r, exp_fail, tag); step();
    endtask

    // Monitor: compare each response with the oldest expectation.
    always @(negedge clk) begin
        if (!rst_n) begin
            n_checks++;
            if (chk_resp_valid !== 1'b0) begin
                n_fail++;
                $display("FAIL R1 resp_valid in reset act=%b exp=0", chk_resp_valid);
            end
        end else if (chk_resp_valid) begin
            n_resp++;
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R12 unexpected response act=1 exp=0");
            end else begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (chk_resp_fail !== e) begin
                    n_fail++;
                    $display("FAIL %s act=%b exp=%b", t, chk_resp_fail, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: empty after reset
        chk(5, 1'b1, "R1 check after reset");
        // R2 and R7
        ins(1, 64'h1000);
        chk(1, 1'b0, "R2 undisturbed entry");
        chk(1, 1'b1, "R7 second check after removal");
        // R3: same word, different offset
        ins(2, 64'h2000);
        st(64'h2005);
        chk(2, 1'b1, "R3 same word store kills");
        ins(3, 64'h3000);
        st(64'h3008);
        chk(3, 1'b0, "R3 next word store keeps");
        // R4: two entries in one word
        ins(4, 64'h4000);
        ins(5, 64'h4004);
        st(64'h4001);
        chk(4, 1'b1, "R4 first match killed");
        chk(5, 1'b1, "R4 second match killed");
        // R5: overwrite by the same register
        ins(6, 64'h5000);
        ins(6, 64'h6000);
        st(64'h5000);
        chk(6, 1'b0, "R5 old word no longer tracked");
        ins(6, 64'h5000);
        ins(6, 64'h6000);
        st(64'h6000);
        chk(6, 1'b1, "R5 new word tracked");
        // R9: store and check in the same cycle
        ins(7, 64'h7000);
        set_st(64'h7000); set_chk(7, 1'b1, "R9 matching store wins"); step();
        ins(8, 64'h8000);
        set_st(64'h9000); set_chk(8, 1'b0, "R9 other store no effect"); step();
        // R11: insert and store in the same cycle
        set_ins(9, 64'hA000); set_st(64'hA000); step();
        chk(9, 1'b0, "R11 fresh insert survives store");
        // R8: flush
        ins(10, 64'hB000);
        ins(11, 64'hB100);
        set_ins(12, 64'hB200); flush = 1'b1; set_chk(10, 1'b1, "R8 check during flush"); step();
        chk(11, 1'b1, "R8 entry gone after flush");
        chk(12, 1'b1, "R8 insert in flush cycle dropped");
        // R6: fill all 16 entries, then evict in rotation
        for (int r = 20; r < 36; r++) begin
            ins(r, 64'h10000 + 64'(r) * 64'h40);
        end
        ins(36, 64'h20000);
        chk(20, 1'b1, "R6 oldest evicted");
        chk(21, 1'b0, "R6 neighbour kept");
        chk(36, 1'b0, "R6 new entry present");
        ins(40, 64'h21000);
        ins(41, 64'h22000);
        ins(42, 64'h23000);
        chk(41, 1'b1, "R6 pointer advanced to entry 1");
        chk(40, 1'b0, "R6 entry 0 kept");
        chk(22, 1'b0, "R6 older entry kept");
        chk(42, 1'b0, "R6 rotated insert present");
        // R10: never inserted
        chk(99, 1'b1, "R10 unknown register");

        repeat (3) step();
        // R12: one response per check
        n_checks++;
        if (n_resp != n_issued || exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R12 response count act=%0d exp=%0d", n_resp, n_issued);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule